// File: doc/BRIEF.md
# Prefetch Queue Trace Rebuilder

This block sits on the trace side of a debug port. It watches a processor's external bus: the address, the data word, the read/write line, the bus E clock and a two-bit pipe status code. From these it rebuilds the processor's prefetch queue, so a debugger can see which opcode begins on each bus cycle. The status code has two meanings. When E rises it is a data-movement command. When E falls it is an execution-start event.

Inside, the block holds a holding latch and two queue stages. Each entry keeps a data word and the address the word was fetched from, plus a valid flag. The block runs on a system clock much faster than E. It finds both E edges through a synchronizer and an edge detector. The bus bundle goes through an equal number of flops, so the bus values stay aligned with E.

On every start event the block gives a one-cycle strobe. The strobe carries the start kind, the selected opcode byte and the address of that byte. A start that needs an empty second stage gives an error pulse and no opcode.

Top module: `pfq_rebuild`

## Requirements
- R1: After reset, `evt_valid` and `evt_err` are low. The fetch capture, the holding latch and both stages are empty, so an even or odd start made before any loads gives the error pulse.
- R2: Each event result is a pulse exactly one system clock wide. It is due on the third rising clock edge after E changes level, with the default two synchronizer stages.
- R3: On an E fall with code 2'b10 (even start) and a valid second stage, the block pulses `evt_valid`. `evt_kind` is 2'b10, `evt_opcode` is bits [15:8] of the second-stage word, and `evt_addr` is that word's fetch address.
- R4: On an E fall with code 2'b11 (odd start) and a valid second stage, the block pulses `evt_valid`. `evt_kind` is 2'b11, `evt_opcode` is bits [7:0] of the second-stage word, and `evt_addr` is the fetch address plus one.
- R5: On an E fall with code 2'b01 (interrupt start), the block pulses `evt_valid` with `evt_kind` 2'b01, and `evt_opcode` and `evt_addr` are both zero. This happens whether the stages are valid or not, and the queue contents do not change.
- R6: An even or odd start made while the second stage is empty pulses `evt_err` with `evt_kind` set to the start code, and `evt_valid` stays low. `evt_valid` and `evt_err` are never high together.
- R7: On an E rise with code 2'b01, the holding latch takes the captured fetch word, its address and its valid flag.
- R8: On an E rise with code 2'b10, the second stage takes the first stage, and the first stage takes the captured fetch word.
- R9: On an E rise with code 2'b11, the second stage takes the first stage, the first stage takes the holding latch, and the latch becomes empty.
- R10: The captured fetch word holds the address and data on the bus at the most recent E fall with `bus_rd` high. An E fall with `bus_rd` low leaves it unchanged.
- R11: Code 2'b00 means no event when E falls and no movement when E rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than E |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Bus address |
| bus_data | input | 2*OW | Bus data word |
| bus_rd | input | 1 | High for a read cycle |
| bus_e | input | 1 | Bus E clock, asynchronous to clk |
| pipe_st | input | 2 | Pipe status code |
| evt_valid | output | 1 | One-cycle strobe for an emitted start event |
| evt_err | output | 1 | One-cycle strobe for a start on an empty second stage |
| evt_kind | output | 2 | Start code of the event |
| evt_opcode | output | OW | Selected opcode byte |
| evt_addr | output | AW | Byte address of the opcode |

## Verification
Every result shows up as a registered pulse on the third rising clock edge after E changes. Two of those edges are synchronizer flops, and the third is the event register. The bench drives the bus and the status code one clock before it toggles E. It samples the event outputs at the falling clock edge after the third rising edge, and samples again one clock later to confirm the pulse has ended. Queue movement has no port of its own. A reference queue kept in the bench predicts the contents, and each movement is checked through the opcode and address that later starts read out. The sweep steps through every pair of movement command and start code, and mixes in write cycles.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

   typedef enum logic [1:0] {
      MV_HOLD    = 2'b00,
      MV_LATCH   = 2'b01,
      MV_ADV_BUS = 2'b10,
      MV_ADV_LAT = 2'b11
   } mv_e;

   typedef enum logic [1:0] {
      ST_NONE = 2'b00,
      ST_INTR = 2'b01,
      ST_EVEN = 2'b10,
      ST_ODD  = 2'b11
   } st_e;

endpackage

// File: rtl/pfq_edge_sync.sv
module pfq_edge_sync #(
   parameter int STAGES = 2,
   parameter int BW     = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          e_in,
   input  logic [BW-1:0] bndl_in,
   output logic          e_rise,
   output logic          e_fall,
   output logic [BW-1:0] bndl_out
);
   logic [STAGES-1:0] e_sh;
   logic [BW-1:0]     b_sh [STAGES];
   logic              e_prev;

   if (STAGES < 2) begin : g_bad_stages
      $error("pfq_edge_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               e_sh[0] <= 1'b0;
               b_sh[0] <= '0;
            end else begin
               e_sh[0] <= e_in;
               b_sh[0] <= bndl_in;
            end
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               e_sh[g] <= 1'b0;
               b_sh[g] <= '0;
            end else begin
               e_sh[g] <= e_sh[g-1];
               b_sh[g] <= b_sh[g-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) e_prev <= 1'b0;
      else        e_prev <= e_sh[STAGES-1];
   end

   assign e_rise   =  e_sh[STAGES-1] & ~e_prev;
   assign e_fall   = ~e_sh[STAGES-1] &  e_prev;
   assign bndl_out =  b_sh[STAGES-1];
endmodule

// File: rtl/pfq_fetch_capture.sv
module pfq_fetch_capture #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          e_fall,
   input  logic          rd,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data,
   output logic [AW-1:0] cap_addr,
   output logic [DW-1:0] cap_data,
   output logic          cap_v
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_addr <= '0;
         cap_data <= '0;
         cap_v    <= 1'b0;
      end else if (e_fall && rd) begin
         cap_addr <= addr;
         cap_data <= data;
         cap_v    <= 1'b1;
      end
   end
endmodule

// File: rtl/pfq_queue.sv
module pfq_queue #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          e_rise,
   input  logic [1:0]    mv_code,
   input  logic [AW-1:0] cap_addr,
   input  logic [DW-1:0] cap_data,
   input  logic          cap_v,
   output logic [AW-1:0] s2_addr,
   output logic [DW-1:0] s2_data,
   output logic          s2_v
);
   import pfq_pkg::*;

   logic [AW-1:0] lat_addr, s1_addr;
   logic [DW-1:0] lat_data, s1_data;
   logic          lat_v, s1_v;
   mv_e           mv;

   assign mv = mv_e'(mv_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_addr <= '0; lat_data <= '0; lat_v <= 1'b0;
         s1_addr  <= '0; s1_data  <= '0; s1_v  <= 1'b0;
         s2_addr  <= '0; s2_data  <= '0; s2_v  <= 1'b0;
      end else if (e_rise) begin
         case (mv)
            MV_LATCH: begin
               lat_addr <= cap_addr;
               lat_data <= cap_data;
               lat_v    <= cap_v;
            end
            MV_ADV_BUS: begin
               s2_addr <= s1_addr; s2_data <= s1_data; s2_v <= s1_v;
               s1_addr <= cap_addr; s1_data <= cap_data; s1_v <= cap_v;
            end
            MV_ADV_LAT: begin
               s2_addr <= s1_addr; s2_data <= s1_data; s2_v <= s1_v;
               s1_addr <= lat_addr; s1_data <= lat_data; s1_v <= lat_v;
               lat_v   <= 1'b0;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pfq_start_emit.sv
module pfq_start_emit #(
   parameter int AW = 16,
   parameter int OW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            e_fall,
   input  logic [1:0]      st_code,
   input  logic [AW-1:0]   s2_addr,
   input  logic [2*OW-1:0] s2_data,
   input  logic            s2_v,
   output logic            evt_valid,
   output logic            evt_err,
   output logic [1:0]      evt_kind,
   output logic [OW-1:0]   evt_opcode,
   output logic [AW-1:0]   evt_addr
);
   import pfq_pkg::*;

   st_e st;
   assign st = st_e'(st_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_valid  <= 1'b0;
         evt_err    <= 1'b0;
         evt_kind   <= 2'b00;
         evt_opcode <= '0;
         evt_addr   <= '0;
      end else begin
         evt_valid <= 1'b0;
         evt_err   <= 1'b0;
         if (e_fall) begin
            case (st)
               ST_INTR: begin
                  evt_valid  <= 1'b1;
                  evt_kind   <= st_code;
                  evt_opcode <= '0;
                  evt_addr   <= '0;
               end
               ST_EVEN: begin
                  evt_kind <= st_code;
                  if (s2_v) begin
                     evt_valid  <= 1'b1;
                     evt_opcode <= s2_data[2*OW-1:OW];
                     evt_addr   <= s2_addr;
                  end else begin
                     evt_err <= 1'b1;
                  end
               end
               ST_ODD: begin
                  evt_kind <= st_code;
                  if (s2_v) begin
                     evt_valid  <= 1'b1;
                     evt_opcode <= s2_data[OW-1:0];
                     evt_addr   <= s2_addr + AW'(1);
                  end else begin
                     evt_err <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/pfq_rebuild.sv
module pfq_rebuild #(
   parameter int AW          = 16,
   parameter int OW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   bus_addr,
   input  logic [2*OW-1:0] bus_data,
   input  logic            bus_rd,
   input  logic            bus_e,
   input  logic [1:0]      pipe_st,
   output logic            evt_valid,
   output logic            evt_err,
   output logic [1:0]      evt_kind,
   output logic [OW-1:0]   evt_opcode,
   output logic [AW-1:0]   evt_addr
);
   localparam int DW = 2 * OW;
   localparam int BW = AW + DW + 1 + 2;

   if (AW < 2) begin : g_bad_aw
      $error("pfq_rebuild: AW must be at least 2");
   end
   if (OW < 1) begin : g_bad_ow
      $error("pfq_rebuild: OW must be at least 1");
   end

   logic          e_rise, e_fall;
   logic [BW-1:0] bndl_s;
   logic [AW-1:0] s_addr, cap_addr, s2_addr;
   logic [DW-1:0] s_data, cap_data, s2_data;
   logic          s_rd, cap_v, s2_v;
   logic [1:0]    s_pipe;

   pfq_edge_sync #(.STAGES(SYNC_STAGES), .BW(BW)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .e_in    (bus_e),
      .bndl_in ({bus_addr, bus_data, bus_rd, pipe_st}),
      .e_rise  (e_rise),
      .e_fall  (e_fall),
      .bndl_out(bndl_s)
   );

   assign {s_addr, s_data, s_rd, s_pipe} = bndl_s;

   pfq_fetch_capture #(.AW(AW), .DW(DW)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .e_fall  (e_fall),
      .rd      (s_rd),
      .addr    (s_addr),
      .data    (s_data),
      .cap_addr(cap_addr),
      .cap_data(cap_data),
      .cap_v   (cap_v)
   );

   pfq_queue #(.AW(AW), .DW(DW)) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .e_rise  (e_rise),
      .mv_code (s_pipe),
      .cap_addr(cap_addr),
      .cap_data(cap_data),
      .cap_v   (cap_v),
      .s2_addr (s2_addr),
      .s2_data (s2_data),
      .s2_v    (s2_v)
   );

   pfq_start_emit #(.AW(AW), .OW(OW)) u_emit (
      .clk       (clk),
      .rst_n     (rst_n),
      .e_fall    (e_fall),
      .st_code   (s_pipe),
      .s2_addr   (s2_addr),
      .s2_data   (s2_data),
      .s2_v      (s2_v),
      .evt_valid (evt_valid),
      .evt_err   (evt_err),
      .evt_kind  (evt_kind),
      .evt_opcode(evt_opcode),
      .evt_addr  (evt_addr)
   );
endmodule

// File: rtl/pfq_rebuild_chk.sv
module pfq_rebuild_chk #(
   parameter int AW = 16,
   parameter int OW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          evt_valid,
   input logic          evt_err,
   input logic [1:0]    evt_kind,
   input logic [OW-1:0] evt_opcode,
   input logic [AW-1:0] evt_addr
);
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!evt_valid && !evt_err));

   a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |=> !evt_valid);

   a_r2_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      evt_err |=> !evt_err);

   a_r5_intr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_kind == 2'b01) |-> (evt_opcode == '0 && evt_addr == '0));

   a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_valid && evt_err));

   a_r6_err_kind: assert property (@(posedge clk) disable iff (!rst_n)
      evt_err |-> evt_kind[1]);

   a_r11_kind_set: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> (evt_kind != 2'b00));
endmodule

bind pfq_rebuild pfq_rebuild_chk #(.AW(AW), .OW(OW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_valid (evt_valid),
   .evt_err   (evt_err),
   .evt_kind  (evt_kind),
   .evt_opcode(evt_opcode),
   .evt_addr  (evt_addr)
);

// File: tb/pfq_rebuild_bench.sv
module pfq_rebuild_bench;
   localparam int AW = 16;
   localparam int OW = 8;
   localparam int DW = 2 * OW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_data = '0;
   logic          bus_rd = 1'b1;
   logic          bus_e = 1'b0;
   logic [1:0]    pipe_st = 2'b00;
   logic          evt_valid, evt_err;
   logic [1:0]    evt_kind;
   logic [OW-1:0] evt_opcode;
   logic [AW-1:0] evt_addr;

   int checks = 0;
   int errors = 0;

   // reference queue
   logic [AW-1:0] m_cap_a, m_lat_a, m_s1_a, m_s2_a;
   logic [DW-1:0] m_cap_d, m_lat_d, m_s1_d, m_s2_d;
   logic          m_cap_v, m_lat_v, m_s1_v, m_s2_v;

   always #4 clk = ~clk;

   pfq_rebuild #(.AW(AW), .OW(OW), .SYNC_STAGES(2)) u_pfq_rebuild (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
      .bus_rd(bus_rd), .bus_e(bus_e), .pipe_st(pipe_st),
      .evt_valid(evt_valid), .evt_err(evt_err), .evt_kind(evt_kind),
      .evt_opcode(evt_opcode), .evt_addr(evt_addr)
   );

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic do_rise(input logic [1:0] mv);
      pipe_st = mv;
      @(negedge clk);
      bus_e = 1'b1;
      repeat (5) @(negedge clk);
      case (mv)
         2'b01: begin m_lat_a = m_cap_a; m_lat_d = m_cap_d; m_lat_v = m_cap_v; end
         2'b10: begin
            m_s2_a = m_s1_a; m_s2_d = m_s1_d; m_s2_v = m_s1_v;
            m_s1_a = m_cap_a; m_s1_d = m_cap_d; m_s1_v = m_cap_v;
         end
         2'b11: begin
            m_s2_a = m_s1_a; m_s2_d = m_s1_d; m_s2_v = m_s1_v;
            m_s1_a = m_lat_a; m_s1_d = m_lat_d; m_s1_v = m_lat_v;
            m_lat_v = 1'b0;
         end
         default: ;
      endcase
   endtask

   task automatic do_fall(input logic [1:0] st, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic rd);
      logic          x_valid, x_err;
      logic [OW-1:0] x_op;
      logic [AW-1:0] x_addr;
      string         tag;
      pipe_st = st; bus_addr = a; bus_data = d; bus_rd = rd;
      @(negedge clk);
      bus_e = 1'b0;
      x_valid = 1'b0; x_err = 1'b0; x_op = '0; x_addr = '0;
      case (st)
         2'b01: begin x_valid = 1'b1; tag = "R5"; end
         2'b10: begin
            tag = m_s2_v ? "R3 (queue per R7 R8 R9 R10)" : "R6";
            x_valid = m_s2_v; x_err = !m_s2_v;
            x_op = m_s2_d[DW-1:OW]; x_addr = m_s2_a;
         end
         2'b11: begin
            tag = m_s2_v ? "R4 (queue per R7 R8 R9 R10)" : "R6";
            x_valid = m_s2_v; x_err = !m_s2_v;
            x_op = m_s2_d[OW-1:0]; x_addr = m_s2_a + AW'(1);
         end
         default: tag = "R11";
      endcase
      repeat (3) @(posedge clk);
      @(negedge clk);
      if (x_valid)
         check(tag, 64'({evt_valid, evt_err, evt_kind, evt_opcode, evt_addr}),
                    64'({x_valid, x_err, st, x_op, x_addr}));
      else if (x_err)
         check(tag, 64'({evt_valid, evt_err, evt_kind}), 64'({x_valid, x_err, st}));
      else
         check(tag, 64'({evt_valid, evt_err}), 64'({x_valid, x_err}));
      @(negedge clk);
      check("R2 pulse ends", 64'({evt_valid, evt_err}), 64'(0));
      if (rd) begin m_cap_a = a; m_cap_d = d; m_cap_v = 1'b1; end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      m_cap_a = '0; m_lat_a = '0; m_s1_a = '0; m_s2_a = '0;
      m_cap_d = '0; m_lat_d = '0; m_s1_d = '0; m_s2_d = '0;
      m_cap_v = 1'b0; m_lat_v = 1'b0; m_s1_v = 1'b0; m_s2_v = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset outputs", 64'({evt_valid, evt_err}), 64'(0));
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 idle after reset", 64'({evt_valid, evt_err}), 64'(0));
      // R1: even and odd starts on an empty queue must give errors
      do_rise(2'b00);
      do_fall(2'b10, 16'h1200, 16'hA1B2, 1'b1);
      do_rise(2'b10);
      do_fall(2'b11, 16'h1202, 16'hC3D4, 1'b1);
      // sweep every movement/start pair with mixed read/write cycles
      for (int i = 0; i < 192; i++) begin
         logic [1:0]    mv, st;
         logic [AW-1:0] a;
         logic [DW-1:0] d;
         mv = 2'(i % 4);
         st = 2'((i / 4) % 4);
         if ((i / 16) % 3 == 1) mv = 2'b10;
         a = AW'(i * 16'h0136 + 16'h0400);
         d = DW'(i * 16'h2B3D) ^ 16'h5A0F;
         do_rise(mv);
         do_fall(st, a, d, (i % 7) != 3);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule